// File: doc/BRIEF.md
# Dual-Speed Repeater Port Receive Qualifier

This block sits between one port's PHY receive signals and a repeater core. It turns raw receive data, data-valid, error, carrier sense and collision into a qualified stream of receive beats. It also produces a registered carrier-active flag, a one-cycle false-carrier pulse and a synchronised collision flag. The port runs either in a slow serial mode, where one bit arrives per receive clock on data line 0, or in a fast nibble mode, where four bits arrive per clock.

When the port starts transmitting, the PHY may echo carrier sense back. The block ignores carrier sense for a speed-dependent window after each transmit start. In fast mode that window is 16 bit times, which is 4 nibble clocks. In slow mode it is 4 bit times, which is 4 serial clocks.

All logic runs in the receive clock domain. The output stream carries only a valid qualifier, because a PHY cannot be stalled. The consumer must take every beat in the cycle it is presented, and no back-pressure path exists.

Top module: `rx_port_qualifier`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `beat_valid`, `carrier_active`, `false_carrier` and `col_sync` are all 0.
- R2: With `cfg_fast`=1, a beat is presented one clock after a cycle in which `rx_dv`=1 and carrier is effective. That beat has `beat_data` equal to the `rx_d` nibble of that cycle.
- R3: With `cfg_fast`=0 and `cfg_dv_qual`=0, every cycle with effective carrier yields a beat one clock later, whatever `rx_dv` is. Its `beat_data` is {3'b000, `rx_d`[0]}, so bits 3:1 are always 0.
- R4: With `cfg_fast`=0 and `cfg_dv_qual`=1, a beat follows only a cycle in which both `rx_dv`=1 and carrier is effective. The data format is the one given in R3.
- R5: A cycle with `crs`=0 never yields a beat in either mode.
- R6: With `cfg_fast`=1 and `cfg_fc_en`=1, the code `rx_dv`=0, `rx_er`=1, `rx_d`=4'b1110 raises `false_carrier` for exactly one clock. The pulse comes one clock after the first cycle of each unbroken run of that code. There is no pulse when `cfg_fc_en`=0. There is also no pulse for a run whose first cycle falls inside the blinding window.
- R7: With `cfg_fast`=0, `rx_er` has no effect: the false-carrier code gives no pulse, and the beats are unchanged.
- R8: After a clock in which `tx_start`=1, `crs` is treated as 0 for the next 4 clocks in either mode. During that window there are no beats, `carrier_active` is 0 and no false-carrier pulse is raised. A new `tx_start` restarts the window.
- R9: `col_sync` equals the value `col_async` had two clocks earlier (two-flop synchroniser).
- R10: `carrier_active` equals effective carrier (`crs` and not blinded) of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fast | input | 1 | 1 = nibble mode, 0 = serial mode |
| cfg_dv_qual | input | 1 | Serial mode: 1 = qualify data with rx_dv, 0 = with carrier only |
| cfg_fc_en | input | 1 | Enable false-carrier reporting |
| tx_start | input | 1 | Pulse when the port begins transmitting |
| rx_d | input | 4 | Receive data (bit 0 only in serial mode) |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| crs | input | 1 | Carrier sense |
| col_async | input | 1 | Collision, asynchronous |
| beat_valid | output | 1 | Qualified beat present (no back-pressure) |
| beat_data | output | 4 | Qualified beat data |
| carrier_active | output | 1 | Registered effective carrier |
| false_carrier | output | 1 | One-cycle false-carrier pulse |
| col_sync | output | 1 | Synchronised collision |

## Verification
The fast-mode nibble sweep with `rx_dv` gaps checks that data-valid gating is separate from carrier gating. Serial runs with junk on the upper data bits, and with `rx_dv` toggling under both settings of the qualifier bit, show which qualifier is in force. False-carrier runs of different lengths, broken runs, near-miss nibbles, a cleared enable and serial mode separate a run-edge detector from a level detector, and show that the detector depends on mode and enable. Transmit starts with carrier held high, including a restart inside the window, check the exact length of the blinding window in both speeds. A collision pattern checks the two-clock delay.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int NIB_W = 4;
  localparam logic [NIB_W-1:0] FC_CODE = 4'b1110;

  typedef struct packed {
    logic             valid;
    logic [NIB_W-1:0] data;
  } rx_beat_t;
endpackage

// File: rtl/rxq_blind.sv
module rxq_blind #(
  parameter int FAST_BITS = 16,
  parameter int SLOW_BITS = 4,
  parameter int NIB       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  input  logic tx_start,
  output logic blinded
);
  localparam int FAST_CYC = FAST_BITS / NIB;
  localparam int SLOW_CYC = SLOW_BITS;
  localparam int MAX_CYC  = (FAST_CYC > SLOW_CYC) ? FAST_CYC : SLOW_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] FAST_LOAD = CW'(FAST_CYC);
  localparam logic [CW-1:0] SLOW_LOAD = CW'(SLOW_CYC);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (tx_start) begin
      remain <= fast ? FAST_LOAD : SLOW_LOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign blinded = (remain != '0);
endmodule

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= 1'b0;
          else        stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[i] <= 1'b0;
          else        stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/rxq_fcdet.sv
module rxq_fcdet
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast,
  input  logic             en,
  input  logic             dv,
  input  logic             er,
  input  logic [NIB_W-1:0] d,
  input  logic             blinded,
  output logic             pulse
);
  logic match;
  logic seen;

  assign match = fast && en && !dv && er && (d == FC_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      seen  <= match;
      pulse <= match && !seen && !blinded;
    end
  end
endmodule

// File: rtl/rx_port_qualifier.sv
module rx_port_qualifier
  import rxq_pkg::*;
#(
  parameter int FAST_BLIND_BITS = 16,
  parameter int SLOW_BLIND_BITS = 4,
  parameter int SYNC_STAGES     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fast,
  input  logic             cfg_dv_qual,
  input  logic             cfg_fc_en,
  input  logic             tx_start,
  input  logic [NIB_W-1:0] rx_d,
  input  logic             rx_dv,
  input  logic             rx_er,
  input  logic             crs,
  input  logic             col_async,
  output logic             beat_valid,
  output logic [NIB_W-1:0] beat_data,
  output logic             carrier_active,
  output logic             false_carrier,
  output logic             col_sync
);
  logic     blinded;
  logic     crs_eff;
  rx_beat_t nxt;
  rx_beat_t beat_q;
  logic     car_q;

  rxq_blind #(
    .FAST_BITS(FAST_BLIND_BITS),
    .SLOW_BITS(SLOW_BLIND_BITS),
    .NIB      (NIB_W)
  ) u_blind (
    .clk     (clk),
    .rst_n   (rst_n),
    .fast    (cfg_fast),
    .tx_start(tx_start),
    .blinded (blinded)
  );

  rxq_sync #(.STAGES(SYNC_STAGES)) u_colsync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (col_async),
    .q    (col_sync)
  );

  rxq_fcdet u_fc (
    .clk    (clk),
    .rst_n  (rst_n),
    .fast   (cfg_fast),
    .en     (cfg_fc_en),
    .dv     (rx_dv),
    .er     (rx_er),
    .d      (rx_d),
    .blinded(blinded),
    .pulse  (false_carrier)
  );

  assign crs_eff = crs && !blinded;

  always_comb begin
    if (cfg_fast) begin
      nxt.valid = crs_eff && rx_dv;
      nxt.data  = rx_d;
    end else begin
      nxt.valid = crs_eff && (cfg_dv_qual ? rx_dv : 1'b1);
      nxt.data  = {{(NIB_W-1){1'b0}}, rx_d[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      car_q  <= 1'b0;
    end else begin
      beat_q.valid <= nxt.valid;
      if (nxt.valid) beat_q.data <= nxt.data;
      car_q <= crs_eff;
    end
  end

  assign beat_valid     = beat_q.valid;
  assign beat_data      = beat_q.data;
  assign carrier_active = car_q;
endmodule

module rxq_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_fast,
  input logic       cfg_fc_en,
  input logic       tx_start,
  input logic       rx_dv,
  input logic       rx_er,
  input logic       crs,
  input logic       col_async,
  input logic       beat_valid,
  input logic [3:0] beat_data,
  input logic       carrier_active,
  input logic       false_carrier,
  input logic       col_sync
);
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R5
  no_beat_without_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(crs) |-> !beat_valid);

  // R3
  serial_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !$past(cfg_fast)) |-> (beat_data[3:1] == 3'b000));

  // R6
  fc_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    false_carrier |=> !false_carrier);

  // R6
  fc_needs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    false_carrier |-> $past(cfg_fast && cfg_fc_en && rx_er && !rx_dv));

  // R8
  blind_no_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && $past(tx_start, 2)) |-> (!carrier_active && !beat_valid));

  // R9
  col_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (col_sync == $past(col_async, 2)));
endmodule

bind rx_port_qualifier rxq_port_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_fast      (cfg_fast),
  .cfg_fc_en     (cfg_fc_en),
  .tx_start      (tx_start),
  .rx_dv         (rx_dv),
  .rx_er         (rx_er),
  .crs           (crs),
  .col_async     (col_async),
  .beat_valid    (beat_valid),
  .beat_data     (beat_data),
  .carrier_active(carrier_active),
  .false_carrier (false_carrier),
  .col_sync      (col_sync)
);

// File: tb/rx_port_qualifier_test.sv
`timescale 1ns/100ps
module rx_port_qualifier_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_fast = 1'b0, cfg_dv_qual = 1'b0, cfg_fc_en = 1'b0, tx_start = 1'b0;
  logic [3:0] rx_d = 4'h0;
  logic       rx_dv = 1'b0, rx_er = 1'b0, crs = 1'b0, col_async = 1'b0;
  logic       beat_valid, carrier_active, false_carrier, col_sync;
  logic [3:0] beat_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  rx_port_qualifier uut (
    .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast), .cfg_dv_qual(cfg_dv_qual),
    .cfg_fc_en(cfg_fc_en), .tx_start(tx_start), .rx_d(rx_d), .rx_dv(rx_dv),
    .rx_er(rx_er), .crs(crs), .col_async(col_async), .beat_valid(beat_valid),
    .beat_data(beat_data), .carrier_active(carrier_active),
    .false_carrier(false_carrier), .col_sync(col_sync)
  );

  // Behavioural reference: blinding window length from bit times per clock
  int m_left = 0;
  bit m_valid = 0, m_car = 0, m_fc = 0, m_seen = 0, m_col = 0;
  int m_data = 0;
  bit col_hist[$];
  int fc_seen_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_valid = 0; m_car = 0; m_fc = 0; m_seen = 0; m_col = 0;
      m_data = 0;
      col_hist.delete();
      col_hist.push_back(1'b0);
    end else begin
      bit bl, ce, match;
      bl = (m_left > 0);
      ce = crs && !bl;
      m_car = ce;
      if (cfg_fast) m_valid = ce && rx_dv;
      else          m_valid = ce && (!cfg_dv_qual || rx_dv);
      if (m_valid) m_data = cfg_fast ? int'(rx_d) : int'(rx_d[0]);
      match = cfg_fast && cfg_fc_en && !rx_dv && rx_er && (rx_d == 4'b1110);
      m_fc = match && !bl && !m_seen;
      m_seen = match;
      m_col = col_hist.pop_front();
      col_hist.push_back(col_async);
      if (tx_start) m_left = cfg_fast ? 16 / 4 : 4 / 1;
      else if (m_left > 0) m_left = m_left - 1;
    end
  end

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", t, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    check({tag, " beat_valid"}, beat_valid, m_valid);
    if (m_valid) check({tag, " beat_data"}, beat_data, m_data);
    check({tag, " carrier_active"}, carrier_active, m_car);
    check({tag, " false_carrier"}, false_carrier, m_fc);
    check("R9 col_sync", col_sync, m_col);
    if (false_carrier) fc_seen_cnt++;
  endtask

  task automatic step(input bit c, input bit dv, input bit er, input logic [3:0] d);
    crs = c; rx_dv = dv; rx_er = er; rx_d = d;
    @(posedge clk);
    @(negedge clk);
    compare_all();
    tx_start = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1 reset
    tag = "R1";
    repeat (3) begin
      @(negedge clk);
      compare_all();
      check("R1 beat_valid in reset", beat_valid, 0);
    end
    rst_n = 1'b1;
    step(0, 0, 0, 4'h0);
    check("R1 first sample after reset", {beat_valid, carrier_active, false_carrier, col_sync}, 0);

    // R2 fast nibbles with dv gaps
    tag = "R2"; cfg_fast = 1;
    for (int i = 0; i < 16; i++) step(1, 1'(i % 5 != 3), 0, 4'(i));
    step(1, 1, 0, 4'hA);
    check("R2 nibble A delivered", beat_data, 4'hA);

    // R5 no carrier
    tag = "R5";
    for (int i = 0; i < 4; i++) step(0, 1, 0, 4'(i + 7));
    cfg_fast = 0;
    for (int i = 0; i < 4; i++) step(0, 1, 0, 4'hF);
    check("R5 no beat without crs", beat_valid, 0);

    // R3 serial, carrier qualifies
    tag = "R3"; cfg_dv_qual = 0;
    for (int i = 0; i < 12; i++) step(1, 1'(i % 3 == 0), 0, {3'b101, 1'(i % 2)});
    step(1, 0, 0, 4'hF);
    check("R3 serial bit with junk upper", beat_data, 4'h1);

    // R4 serial, data-valid qualifies
    tag = "R4"; cfg_dv_qual = 1;
    for (int i = 0; i < 12; i++) step(1'(i != 9), 1'(i % 2), 0, 4'(i));
    step(1, 0, 0, 4'h1);
    check("R4 dv low gives no beat", beat_valid, 0);

    // R6 false carrier
    tag = "R6"; cfg_fast = 1; cfg_fc_en = 1; fc_seen_cnt = 0;
    for (int i = 0; i < 3; i++) step(1, 0, 1, 4'b1110);
    step(1, 0, 1, 4'b1101);
    step(1, 0, 1, 4'b1110);
    step(1, 0, 1, 4'b1110);
    step(1, 0, 0, 4'b1110);
    step(1, 1, 1, 4'b1110);
    step(1, 0, 0, 4'h0);
    check("R6 pulses per run", fc_seen_cnt, 2);
    cfg_fc_en = 0; fc_seen_cnt = 0;
    for (int i = 0; i < 3; i++) step(1, 0, 1, 4'b1110);
    step(0, 0, 0, 4'h0);
    check("R6 disabled gives no pulse", fc_seen_cnt, 0);

    // R7 error ignored in serial mode
    tag = "R7"; cfg_fast = 0; cfg_fc_en = 1; cfg_dv_qual = 0; fc_seen_cnt = 0;
    for (int i = 0; i < 6; i++) step(1, 0, 1'(i % 2 == 0), 4'b1110 | 4'(i % 2));
    step(1, 0, 1, 4'b1110);
    check("R7 no pulse in serial mode", fc_seen_cnt, 0);

    // R8 blinding, fast then serial, and restart
    tag = "R8"; cfg_fast = 1;
    step(1, 1, 0, 4'h3);
    tx_start = 1; step(1, 1, 0, 4'h4);
    for (int i = 0; i < 6; i++) step(1, 1, 0, 4'(i));
    tx_start = 1; step(1, 0, 1, 4'b1110);
    for (int i = 0; i < 2; i++) step(1, 0, 1, 4'b1110);
    tx_start = 1; step(1, 1, 0, 4'h1);
    step(1, 1, 0, 4'h2);
    check("R8 carrier blinded in window", carrier_active, 0);
    for (int i = 0; i < 5; i++) step(1, 1, 0, 4'h5);
    check("R8 carrier back after window", carrier_active, 1);
    cfg_fast = 0;
    tx_start = 1; step(1, 1, 0, 4'h1);
    for (int i = 0; i < 6; i++) step(1, 1, 0, 4'h1);

    // R10 carrier follows crs
    tag = "R10";
    for (int i = 0; i < 8; i++) step(1'(i % 3 != 0), 0, 0, 4'h0);

    // R9 collision synchroniser
    tag = "R9";
    for (int i = 0; i < 12; i++) begin
      col_async = 1'((i / 2) % 2 == 1) ^ 1'(i == 7);
      step(1, 1, 0, 4'h0);
    end
    col_async = 0;
    step(0, 0, 0, 4'h0);
    step(0, 0, 0, 4'h0);
    check("R9 col cleared", col_sync, 0);

    summary();
  end
endmodule